// File: doc/BRIEF.md
# At-Speed Transition Test Sequencer

This block drives a scan chain through one complete test. It produces three things: the scan-enable level, a one-cycle clock-enable pulse for each scan clock, and a select line that tells an external clock multiplexer whether to use the slow clock or the fast one. A single start request runs one full sequence. That sequence loads the chain, applies the capture cycle or cycles, and reports completion on a one-cycle done strobe.

The block has three test styles, chosen by a mode input that is sampled at start.

- **Broadside style.** The whole chain is loaded at slow speed with scan enable high. Scan enable then drops, and two fast pulses follow back to back. The first pulse launches the transition and the second captures the response.
- **Skewed-load style.** All bits but the last are loaded at slow speed. The last bit is shifted by a fast pulse with scan enable still high. The very next fast pulse captures with scan enable low.
- **Stuck-at style.** This style needs no fast clock. The chain is loaded slowly and then captured once at slow speed.

Slow pulses come once every `DIV` base-clock cycles. Fast pulses come on consecutive base-clock cycles. The speed select never switches in a cycle next to an active pulse, so the clock multiplexer always changes over while no clock is being passed.

Top module: `delay_test_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, scan enable, clock-enable, speed select and done are all low.
- R2: In broadside mode (mode code 2'b01) with chain length n, the block issues exactly n slow load pulses: pulse high, speed select low, scan enable high.
- R3: The first slow pulse appears DIV−1 cycles after the cycle in which start was sampled. Consecutive slow pulses are exactly DIV cycles apart, and a slow stuck-at capture follows the last load pulse by DIV cycles.
- R4: In broadside mode, the load is followed by exactly two fast pulses (speed select high) on consecutive cycles, both with scan enable low.
- R5: In skewed-load mode (mode code 2'b10) with chain length n, the block issues n−1 slow load pulses. These are followed by a fast pulse with scan enable high and, on the very next cycle, a fast pulse with scan enable low.
- R6: In stuck-at mode (mode code 2'b00, and code 2'b11 which acts the same), the block issues n slow load pulses and then one slow capture pulse with scan enable low. Speed select stays low for the whole sequence.
- R7: Speed select changes value only when the clock-enable pulse is low both in the cycle of the change and in the cycle before it.
- R8: Done is high for exactly one cycle, with all other outputs low. It comes two cycles after the final fast pulse, or one cycle after a slow capture. The block then accepts a new start.
- R9: A start request that arrives while a sequence is running is ignored. The running sequence continues with its original mode and length.
- R10: A load count of zero skips the slow phase entirely. This happens with chain length 0 in broadside or stuck-at mode, and with chain length 0 or 1 in skewed-load mode. The capture part of the sequence still runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a sequence when the block is idle |
| mode_i | input | 2 | Test style: 00 stuck-at, 01 broadside, 10 skewed-load, 11 stuck-at |
| chain_len_i | input | LEN_W | Number of cells in the scan chain |
| scan_en_o | output | 1 | Scan enable for the chain |
| clk_en_o | output | 1 | One-cycle clock-enable pulse for the chain clock |
| fast_sel_o | output | 1 | Clock multiplexer select: 1 fast, 0 slow |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The assertions assume that reset is applied from time zero. They also assume that mode and chain length are valid in the cycle where start is accepted; after that the block keeps its own copies, so later changes to these inputs do not matter. The stimulus drives start for a single cycle from the falling edge and holds mode and length steady around that cycle. It deliberately raises start a second time, with a different mode, in the middle of a sequence to exercise the rule that start is ignored while busy. Chain lengths are kept small, including the zero and one cases, so that each sequence finishes within a few hundred cycles.

// File: rtl/dts_pkg.sv
package dts_pkg;

    typedef enum logic [1:0] {
        MODE_STUCK = 2'b00,
        MODE_LOC   = 2'b01,
        MODE_LOS   = 2'b10,
        MODE_ALT   = 2'b11
    } test_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_SETTLE,
        ST_ARM,
        ST_LSHIFT,
        ST_LAUNCH,
        ST_CAPT,
        ST_COOL,
        ST_SCAP,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic scan_en;
        logic pulse;
        logic fast;
        logic done;
    } drive_t;

    function automatic logic is_stuck(test_mode_e m);
        return (m == MODE_STUCK) || (m == MODE_ALT);
    endfunction

    function automatic logic is_skewed(test_mode_e m);
        return m == MODE_LOS;
    endfunction

    // Number of slow load pulses for a given style and chain length.
    function automatic int unsigned slow_loads(test_mode_e m, int unsigned len);
        if (is_skewed(m))
            return (len == 0) ? 0 : len - 1;
        return len;
    endfunction

endpackage

// File: rtl/dts_slow_div.sv
module dts_slow_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV <= 1) begin : g_every
            assign tick = run;
        end else begin : g_count
            localparam logic [DW-1:0] LAST = DW'(DIV - 1);
            logic [DW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !run)
                    cnt <= '0;
                else if (cnt == LAST)
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end

            assign tick = run && (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/dts_shift_cnt.sv
module dts_shift_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    logic [W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst)
            remaining <= '0;
        else if (load)
            remaining <= load_val;
        else if (dec && remaining != '0)
            remaining <= remaining - 1'b1;
    end

    assign last = (remaining == W'(1));
endmodule

// File: rtl/dts_ctrl.sv
module dts_ctrl
    import dts_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  test_mode_e       mode,
    input  logic [LEN_W-1:0] chain_len,
    input  logic             tick,
    input  logic             cnt_last,
    output logic             cnt_load,
    output logic [LEN_W-1:0] cnt_val,
    output logic             cnt_dec,
    output logic             div_run,
    output drive_t           drv
);
    seq_state_e state, nxt;
    test_mode_e mode_q;
    logic       stuck_q, skew_q;

    assign stuck_q = is_stuck(mode_q);
    assign skew_q  = is_skewed(mode_q);
    assign cnt_val = LEN_W'(slow_loads(mode, 32'(chain_len)));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            mode_q <= MODE_STUCK;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start)
                mode_q <= mode;
        end
    end

    always_comb begin
        nxt      = state;
        drv      = '0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        div_run  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    cnt_load = 1'b1;
                    if (cnt_val != '0)
                        nxt = ST_SHIFT;
                    else if (is_stuck(mode))
                        nxt = ST_SCAP;
                    else
                        nxt = ST_SETTLE;
                end
            end
            ST_SHIFT: begin
                div_run     = 1'b1;
                drv.scan_en = 1'b1;
                drv.pulse   = tick;
                cnt_dec     = tick;
                if (tick && cnt_last)
                    nxt = stuck_q ? ST_SCAP : ST_SETTLE;
            end
            ST_SETTLE: begin
                drv.scan_en = skew_q;
                nxt         = ST_ARM;
            end
            ST_ARM: begin
                drv.fast    = 1'b1;
                drv.scan_en = skew_q;
                nxt         = skew_q ? ST_LSHIFT : ST_LAUNCH;
            end
            ST_LSHIFT: begin
                drv.fast    = 1'b1;
                drv.pulse   = 1'b1;
                drv.scan_en = 1'b1;
                nxt         = ST_CAPT;
            end
            ST_LAUNCH: begin
                drv.fast  = 1'b1;
                drv.pulse = 1'b1;
                nxt       = ST_CAPT;
            end
            ST_CAPT: begin
                drv.fast  = 1'b1;
                drv.pulse = 1'b1;
                nxt       = ST_COOL;
            end
            ST_COOL: begin
                drv.fast = 1'b1;
                nxt      = ST_DONE;
            end
            ST_SCAP: begin
                div_run   = 1'b1;
                drv.pulse = tick;
                if (tick)
                    nxt = ST_DONE;
            end
            ST_DONE: begin
                drv.done = 1'b1;
                nxt      = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/delay_test_seq.sv
module delay_test_seq
    import dts_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int DIV   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic [LEN_W-1:0] chain_len_i,
    output logic             scan_en_o,
    output logic             clk_en_o,
    output logic             fast_sel_o,
    output logic             done_o
);
    logic             tick, cnt_last, cnt_load, cnt_dec, div_run;
    logic [LEN_W-1:0] cnt_val;
    drive_t           drv;

    dts_slow_div #(.DIV(DIV)) div_i (
        .clk  (clk),
        .rst  (rst),
        .run  (div_run),
        .tick (tick)
    );

    dts_shift_cnt #(.W(LEN_W)) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    dts_ctrl #(.LEN_W(LEN_W)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .mode      (test_mode_e'(mode_i)),
        .chain_len (chain_len_i),
        .tick      (tick),
        .cnt_last  (cnt_last),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .cnt_dec   (cnt_dec),
        .div_run   (div_run),
        .drv       (drv)
    );

    assign scan_en_o  = drv.scan_en;
    assign clk_en_o   = drv.pulse;
    assign fast_sel_o = drv.fast;
    assign done_o     = drv.done;
endmodule

// File: rtl/dts_checker.sv
module dts_checker (
    input logic clk,
    input logic rst,
    input logic scan_en,
    input logic clk_en,
    input logic fast_sel,
    input logic done
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!scan_en && !clk_en && !fast_sel && !done));

    assert_mux_switch_safe_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(fast_sel) |-> (!clk_en && !$past(clk_en)));

    assert_skew_capture_follows_R5: assert property (@(posedge clk) disable iff (rst)
        (clk_en && fast_sel && scan_en) |=> (clk_en && fast_sel && !scan_en));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_alone_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!clk_en && !scan_en && !fast_sel));

    assert_fast_gap_before_done_R8: assert property (@(posedge clk) disable iff (rst)
        (done && $past(fast_sel)) |-> !$past(clk_en));
endmodule

bind delay_test_seq dts_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .scan_en  (scan_en_o),
    .clk_en   (clk_en_o),
    .fast_sel (fast_sel_o),
    .done     (done_o)
);

// File: tb/delay_test_seq_tb_top.sv
`timescale 1ns/1ps
module delay_test_seq_tb_top;
    localparam int LEN_W = 8;
    localparam int DIV   = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [1:0]       mode_i = 2'b00;
    logic [LEN_W-1:0] chain_len_i = '0;
    logic             scan_en_o, clk_en_o, fast_sel_o, done_o;

    int n_chk  = 0;
    int n_fail = 0;

    // results of the last run
    int r_shift, r_first, r_last, r_mingap, r_maxgap;
    int r_nfast, r_f0, r_f1, r_fse0, r_fse1;
    int r_ncap, r_cap, r_done, r_ndone, r_glitch, r_fasthi;

    always #10 clk = ~clk;

    delay_test_seq #(.LEN_W(LEN_W), .DIV(DIV)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .chain_len_i (chain_len_i),
        .scan_en_o   (scan_en_o),
        .clk_en_o    (clk_en_o),
        .fast_sel_o  (fast_sel_o),
        .done_o      (done_o)
    );

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog: got 0 expected 1 (run did not complete)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Runs one sequence; optional second start at index mid_at with another mode.
    task automatic run_case(input logic [1:0] m, input int len, input int mid_at,
                            input logic [1:0] mid_mode);
        int  prev_gap_idx;
        logic pp, pf;
        int  after;
        @(negedge clk);
        mode_i = m; chain_len_i = LEN_W'(len); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        r_shift = 0; r_first = -1; r_last = -1; r_mingap = 1 << 30; r_maxgap = -1;
        r_nfast = 0; r_f0 = -1; r_f1 = -1; r_fse0 = -1; r_fse1 = -1;
        r_ncap = 0; r_cap = -1; r_done = -1; r_ndone = 0; r_glitch = 0; r_fasthi = 0;
        pp = 1'b0; pf = 1'b0; after = -1; prev_gap_idx = -1;
        for (int i = 0; i < 3000; i++) begin
            if (clk_en_o && !fast_sel_o && scan_en_o) begin
                if (r_first < 0) r_first = i;
                if (r_last >= 0) begin
                    if (i - r_last < r_mingap) r_mingap = i - r_last;
                    if (i - r_last > r_maxgap) r_maxgap = i - r_last;
                end
                r_last = i;
                r_shift++;
            end
            if (clk_en_o && !fast_sel_o && !scan_en_o) begin
                r_ncap++; r_cap = i;
            end
            if (clk_en_o && fast_sel_o) begin
                if (r_nfast == 0) begin r_f0 = i; r_fse0 = int'(scan_en_o); end
                if (r_nfast == 1) begin r_f1 = i; r_fse1 = int'(scan_en_o); end
                r_nfast++;
            end
            if (fast_sel_o) r_fasthi++;
            if ((fast_sel_o != pf) && (clk_en_o || pp)) r_glitch++;
            if (done_o) begin
                r_ndone++;
                if (r_done < 0) begin
                    r_done = i;
                    after = 3;
                end
            end
            pp = clk_en_o; pf = fast_sel_o;
            if (i == mid_at) begin
                mode_i = mid_mode; chain_len_i = LEN_W'(len + 3); start_i = 1'b1;
            end else if (i == mid_at + 1) begin
                start_i = 1'b0;
            end
            if (after == 0) break;
            if (after > 0) after--;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 scan_en in reset", int'(scan_en_o), 0);
        chk("R1 clk_en in reset", int'(clk_en_o), 0);
        chk("R1 fast_sel in reset", int'(fast_sel_o), 0);
        chk("R1 done in reset", int'(done_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", int'({scan_en_o, clk_en_o, fast_sel_o, done_o}), 0);
    endtask

    task automatic t_broadside(int len);
        run_case(2'b01, len, -10, 2'b00);
        chk("R2 broadside slow loads", r_shift, len);
        if (len > 0) chk("R3 first slow pulse index", r_first, DIV - 1);
        if (len > 1) begin
            chk("R3 min slow spacing", r_mingap, DIV);
            chk("R3 max slow spacing", r_maxgap, DIV);
        end
        chk("R4 broadside fast pulses", r_nfast, 2);
        chk("R4 fast pulses consecutive", r_f1 - r_f0, 1);
        chk("R4 launch scan_en low", r_fse0, 0);
        chk("R4 capture scan_en low", r_fse1, 0);
        chk("R7 no switch near pulse", r_glitch, 0);
        chk("R8 done after fast capture", r_done - r_f1, 2);
        chk("R8 done width", r_ndone, 1);
    endtask

    task automatic t_skewed(int len);
        int exp_loads;
        exp_loads = (len == 0) ? 0 : len - 1;
        run_case(2'b10, len, -10, 2'b00);
        chk("R5 skewed slow loads", r_shift, exp_loads);
        if (exp_loads == 0) chk("R10 no slow phase", r_first, -1);
        chk("R5 skewed fast pulses", r_nfast, 2);
        chk("R5 fast pulses consecutive", r_f1 - r_f0, 1);
        chk("R5 last load scan_en high", r_fse0, 1);
        chk("R5 capture scan_en low", r_fse1, 0);
        chk("R7 no switch near pulse", r_glitch, 0);
        chk("R8 done after fast capture", r_done - r_f1, 2);
    endtask

    task automatic t_stuck(logic [1:0] m, int len);
        run_case(m, len, -10, 2'b00);
        chk("R6 stuck slow loads", r_shift, len);
        chk("R6 single slow capture", r_ncap, 1);
        chk("R6 no fast pulses", r_nfast, 0);
        chk("R6 fast select never high", r_fasthi, 0);
        if (len > 0) chk("R3 capture spacing", r_cap - r_last, DIV);
        else chk("R10 stuck capture index", r_cap, DIV - 1);
        chk("R8 done after slow capture", r_done - r_cap, 1);
        chk("R8 done width", r_ndone, 1);
    endtask

    task automatic t_busy_start();
        run_case(2'b01, 3, 5, 2'b10);
        chk("R9 loads unchanged by late start", r_shift, 3);
        chk("R9 style unchanged by late start", r_fse0, 0);
        chk("R9 fast count unchanged", r_nfast, 2);
        chk("R9 single done", r_ndone, 1);
        @(negedge clk);
        chk("R9 idle after run", int'({scan_en_o, clk_en_o, fast_sel_o}), 0);
        // a fresh start must be accepted afterwards
        run_case(2'b10, 2, -10, 2'b00);
        chk("R8 restart accepted", r_shift, 1);
    endtask

    initial begin
        t_reset();
        t_broadside(5);
        t_broadside(1);
        t_broadside(0);
        t_skewed(5);
        t_skewed(1);
        t_skewed(0);
        t_stuck(2'b00, 3);
        t_stuck(2'b11, 2);
        t_stuck(2'b00, 0);
        t_busy_start();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule